// File: doc/BRIEF.md
# Multiply-by-constant arithmetic code checker and corrector

This block sits on the return path of an analog in-memory multiply array. Operands are written into the array pre-multiplied by a fixed odd constant A. Multiplication distributes over addition, so any accumulated dot product that comes back from the array is itself a multiple of A unless the analog path disturbed it.

For each beat, the block takes the raw accumulated word with a valid strobe and reduces it modulo A. A zero remainder means the word is clean, and the block divides it exactly by A. A nonzero remainder selects an entry in a constant correction table. Each table entry names one bit position and a direction, so that adding or removing that single power of two restores a multiple of A. The block then divides the repaired word by A. If no single-position error explains the remainder, the block flags the beat uncorrectable and returns the truncated quotient of the unrepaired word.

A per-beat protect flag lets the less accuracy-critical parts of a computation skip the code altogether. Those beats pass through unchanged and unflagged. A small combinational helper multiplies operands by A so that the write side can encode them. Results leave through a two-stage registered pipeline that keeps beat order.

Top module: `anc_corrector`

## Requirements
- R1: The helper output `enc_code` equals `enc_data` multiplied by A at all times, combinationally.
- R2: A beat sampled with `in_valid` high at a rising edge appears with `out_valid` high exactly two rising edges later. Each beat gives exactly one output beat, outputs come out in input order, and `out_valid` is low in every other cycle.
- R3: For a protected beat (`in_protect`=1) whose word is a multiple of A, `out_data` is the word divided by A, and `out_err_det`, `out_err_fix` and `out_err_unc` are all 0.
- R4: For a protected beat with nonzero remainder r, the block first looks for the lowest i (0 ≤ i < CW_W) with (−2^i) mod A = r, meaning a cell that should read 1 read low. If one exists, 2^i is added to the word. Otherwise it looks for the lowest i with 2^i mod A = r, and if one exists, 2^i is subtracted. All word arithmetic is modulo 2^CW_W. When either search succeeds, `out_data` is the repaired word divided by A, `out_err_det`=1, `out_err_fix`=1 and `out_err_unc`=0.
- R5: For a protected beat with a nonzero remainder that matches neither search, `out_data` is floor(word / A), `out_err_det`=1, `out_err_unc`=1 and `out_err_fix`=0.
- R6: For an unprotected beat (`in_protect`=0), `out_data` is the low Q_W bits of the word, and all three flags are 0.
- R7: In cycles without an output beat, `out_data` and the three flags hold the values of the last output beat.
- R8: While reset is asserted, `out_valid`, `out_data` and all flags are 0. Reset asserts asynchronously and releases synchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| in_valid | input | 1 | Input beat strobe |
| in_protect | input | 1 | 1: check and correct the beat; 0: pass the beat through |
| in_code | input | CW_W (24) | Raw accumulated word |
| out_valid | output | 1 | Output beat strobe |
| out_data | output | Q_W (17) | Decoded or passed-through value |
| out_err_det | output | 1 | Nonzero remainder seen |
| out_err_fix | output | 1 | Single-position repair applied |
| out_err_unc | output | 1 | Remainder not explained by any single-position error |
| enc_data | input | DATA_W (12) | Operand to encode |
| enc_code | output | CW_W (24) | Operand multiplied by A |

## Verification
The encoder output is combinational, so it is sampled on the falling edge after its operand is driven. Every corrector result is due at the second rising edge after the edge that sampled its beat.

The bench drives beat k on falling edge k and checks the output of beat k−2 on falling edge k, half a period after that second register has loaded. This gives back-to-back streams and order checking with no extra alignment. After each stream, three idle falling edges confirm that the strobe is low and that data and flags hold.

// File: rtl/anc_pkg.sv
package anc_pkg;

  localparam int unsigned SH_W = 8;

  // one repair: ok marks a usable entry, sub selects subtraction of 2^sh
  typedef struct packed {
    logic            ok;
    logic            sub;
    logic [SH_W-1:0] sh;
  } fix_t;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'd0,
    ST_FIXED = 2'd1,
    ST_UNCOR = 2'd2,
    ST_RAW   = 2'd3
  } stat_e;

endpackage

// File: rtl/anc_encode.sv
module anc_encode #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned A      = 233,
  parameter int unsigned CW_W   = 24
) (
  input  logic [DATA_W-1:0] data,
  output logic [CW_W-1:0]   code
);

  assign code = CW_W'(data) * CW_W'(A);

endmodule

// File: rtl/anc_residue_lut.sv
module anc_residue_lut
  import anc_pkg::*;
#(
  parameter int unsigned A    = 233,
  parameter int unsigned CW_W = 24,
  localparam int unsigned RES_W = $clog2(A)
) (
  input  logic [CW_W-1:0] code,
  input  logic            protect,
  output stat_e           stat,
  output fix_t            fix
);

  // Elaboration-time entry: low-read cells (word lost 2^i) win over high reads.
  function automatic fix_t build_entry(input int unsigned r);
    fix_t        e;
    int unsigned p;
    e = '0;
    if (r != 0) begin
      p = 1 % A;
      for (int i = 0; i < int'(CW_W); i++) begin
        if (!e.ok && ((A - p) % A) == r) begin
          e.ok  = 1'b1;
          e.sub = 1'b0;
          e.sh  = SH_W'(i);
        end
        p = (p * 2) % A;
      end
      p = 1 % A;
      for (int i = 0; i < int'(CW_W); i++) begin
        if (!e.ok && p == r) begin
          e.ok  = 1'b1;
          e.sub = 1'b1;
          e.sh  = SH_W'(i);
        end
        p = (p * 2) % A;
      end
    end
    return e;
  endfunction

  fix_t             table_q [A];
  logic [RES_W-1:0] res;
  fix_t             ent;

  for (genvar r = 0; r < int'(A); r++) begin : g_tab
    localparam fix_t ENT = build_entry(r);
    assign table_q[r] = ENT;
  end

  assign res = RES_W'(code % CW_W'(A));
  assign ent = table_q[res];

  always_comb begin
    if (!protect)           stat = ST_RAW;
    else if (res == '0)     stat = ST_CLEAN;
    else if (ent.ok)        stat = ST_FIXED;
    else                    stat = ST_UNCOR;
  end

  assign fix = ent;

endmodule

// File: rtl/anc_fix_divide.sv
module anc_fix_divide
  import anc_pkg::*;
#(
  parameter int unsigned A    = 233,
  parameter int unsigned CW_W = 24,
  parameter int unsigned Q_W  = 17
) (
  input  logic [CW_W-1:0] code,
  input  stat_e           stat,
  input  fix_t            fix,
  output logic [Q_W-1:0]  q,
  output logic            det,
  output logic            fixed,
  output logic            uncor
);

  logic [CW_W-1:0] delta;
  logic [CW_W-1:0] repaired;
  logic [CW_W-1:0] src;

  assign delta    = CW_W'(1) << fix.sh;
  assign repaired = fix.sub ? (code - delta) : (code + delta);
  assign src      = (stat == ST_FIXED) ? repaired : code;

  always_comb begin
    if (stat == ST_RAW) q = Q_W'(code);
    else                q = Q_W'(src / CW_W'(A));
  end

  assign fixed = (stat == ST_FIXED);
  assign uncor = (stat == ST_UNCOR);
  assign det   = fixed | uncor;

endmodule

// File: rtl/anc_corrector.sv
module anc_corrector
  import anc_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned A      = 233,
  parameter int unsigned HEAD_W = 4,
  localparam int unsigned RES_W = $clog2(A),
  localparam int unsigned CW_W  = DATA_W + RES_W + HEAD_W,
  localparam int unsigned Q_W   = CW_W - RES_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_protect,
  input  logic [CW_W-1:0]   in_code,
  output logic              out_valid,
  output logic [Q_W-1:0]    out_data,
  output logic              out_err_det,
  output logic              out_err_fix,
  output logic              out_err_unc,
  input  logic [DATA_W-1:0] enc_data,
  output logic [CW_W-1:0]   enc_code
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  anc_encode #(.DATA_W(DATA_W), .A(A), .CW_W(CW_W)) u_enc (
    .data (enc_data),
    .code (enc_code)
  );

  // stage 1: remainder and table lookup
  stat_e lk_stat;
  fix_t  lk_fix;

  anc_residue_lut #(.A(A), .CW_W(CW_W)) u_lut (
    .code    (in_code),
    .protect (in_protect),
    .stat    (lk_stat),
    .fix     (lk_fix)
  );

  logic            s1_vld, s1_vld_d, s1_ld;
  logic [CW_W-1:0] s1_code;
  stat_e           s1_stat;
  fix_t            s1_fix;

  always_comb begin
    s1_vld_d = in_valid;
    s1_ld    = in_valid;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s1_vld  <= 1'b0;
      s1_code <= '0;
      s1_stat <= ST_CLEAN;
      s1_fix  <= '0;
    end else begin
      s1_vld <= s1_vld_d;
      if (s1_ld) begin
        s1_code <= in_code;
        s1_stat <= lk_stat;
        s1_fix  <= lk_fix;
      end
    end
  end

  // stage 2: repair and exact division
  logic [Q_W-1:0] dv_q;
  logic           dv_det, dv_fix, dv_unc;

  anc_fix_divide #(.A(A), .CW_W(CW_W), .Q_W(Q_W)) u_div (
    .code  (s1_code),
    .stat  (s1_stat),
    .fix   (s1_fix),
    .q     (dv_q),
    .det   (dv_det),
    .fixed (dv_fix),
    .uncor (dv_unc)
  );

  logic out_ld, out_valid_d;

  always_comb begin
    out_valid_d = s1_vld;
    out_ld      = s1_vld;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_err_det <= 1'b0;
      out_err_fix <= 1'b0;
      out_err_unc <= 1'b0;
    end else begin
      out_valid <= out_valid_d;
      if (out_ld) begin
        out_data    <= dv_q;
        out_err_det <= dv_det;
        out_err_fix <= dv_fix;
        out_err_unc <= dv_unc;
      end
    end
  end

endmodule

// File: rtl/anc_corrector_chk.sv
module anc_corrector_chk
  import anc_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned A      = 233,
  parameter int unsigned CW_W   = 24,
  parameter int unsigned Q_W    = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              s1_vld,
  input stat_e             s1_stat,
  input logic              out_valid,
  input logic [Q_W-1:0]    out_data,
  input logic              out_err_det,
  input logic              out_err_fix,
  input logic              out_err_unc,
  input logic [DATA_W-1:0] enc_data,
  input logic [CW_W-1:0]   enc_code
);

  AST_ENC_MULTIPLE: assert property (@(posedge clk) disable iff (!rst_n)
    ((enc_code % CW_W'(A)) == '0) && (DATA_W'(enc_code / CW_W'(A)) == enc_data)); // R1

  AST_STAGE1_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_vld); // R2

  AST_STAGE2_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |=> out_valid); // R2

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> !out_valid); // R2

  AST_FIX_IMPLIES_DET: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err_fix) |-> out_err_det); // R4

  AST_FIX_UNC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_err_fix && out_err_unc)); // R5

  AST_BYPASS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld && s1_stat == ST_RAW) |=> !out_err_det && !out_err_fix && !out_err_unc); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> $stable(out_data) && $stable(out_err_det) &&
                $stable(out_err_fix) && $stable(out_err_unc)); // R7

endmodule

bind anc_corrector anc_corrector_chk #(
  .DATA_W (DATA_W),
  .A      (A),
  .CW_W   (CW_W),
  .Q_W    (Q_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .in_valid    (in_valid),
  .s1_vld      (s1_vld),
  .s1_stat     (s1_stat),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_err_det (out_err_det),
  .out_err_fix (out_err_fix),
  .out_err_unc (out_err_unc),
  .enc_data    (enc_data),
  .enc_code    (enc_code)
);

// File: tb/anc_corrector_bench.sv
`timescale 1ns/1ps
module anc_corrector_bench;

  localparam int unsigned DATA_W = 12;
  localparam int unsigned A      = 233;
  localparam int unsigned HEAD_W = 4;
  localparam int unsigned RES_W  = $clog2(A);
  localparam int unsigned CW_W   = DATA_W + RES_W + HEAD_W;
  localparam int unsigned Q_W    = CW_W - RES_W + 1;
  localparam longint unsigned CMASK = (64'd1 << CW_W) - 1;
  localparam longint unsigned QMASK = (64'd1 << Q_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid, in_protect;
  logic [CW_W-1:0]   in_code;
  logic              out_valid;
  logic [Q_W-1:0]    out_data;
  logic              out_err_det, out_err_fix, out_err_unc;
  logic [DATA_W-1:0] enc_data;
  logic [CW_W-1:0]   enc_code;

  always #2.5 clk = ~clk;

  anc_corrector u_anc_corrector (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_protect(in_protect),
    .in_code(in_code), .out_valid(out_valid), .out_data(out_data),
    .out_err_det(out_err_det), .out_err_fix(out_err_fix), .out_err_unc(out_err_unc),
    .enc_data(enc_data), .enc_code(enc_code)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  longint unsigned bq_code [64];
  bit              bq_prot [64];
  int              bq_n;

  task automatic check(input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference model taken from the requirements
  function automatic void model(input longint unsigned code, input bit prot,
                                output longint unsigned d, output bit det,
                                output bit fix, output bit unc, output string req);
    longint unsigned r, p, c;
    bit found;
    det = 0; fix = 0; unc = 0; found = 0; c = code;
    if (!prot) begin
      d = code & QMASK; req = "R6";
      return;
    end
    r = code % A;
    if (r == 0) begin
      d = code / A; req = "R3";
      return;
    end
    for (int i = 0; i < int'(CW_W); i++) begin
      p = (64'd1 << i) % A;
      if (!found && ((A - p) % A) == r) begin
        found = 1; c = (code + (64'd1 << i)) & CMASK;
      end
    end
    for (int i = 0; i < int'(CW_W); i++) begin
      p = (64'd1 << i) % A;
      if (!found && p == r) begin
        found = 1; c = (code - (64'd1 << i)) & CMASK;
      end
    end
    det = 1;
    if (found) begin
      fix = 1; d = (c / A) & QMASK; req = "R4";
    end else begin
      unc = 1; d = (code / A) & QMASK; req = "R5";
    end
  endfunction

  function automatic longint unsigned clean_sum(input int n_ops);
    longint unsigned s = 0;
    for (int k = 0; k < n_ops; k++) s += longint'($urandom_range(0, (1 << DATA_W) - 1));
    return (s * A) & CMASK;
  endfunction

  // drive beats back to back; beat k comes out on falling edge k+2
  task automatic run_beats();
    longint unsigned d, last_d;
    bit det, fix, unc, l_det, l_fix, l_unc;
    string req;
    last_d = 0; l_det = 0; l_fix = 0; l_unc = 0;
    for (int j = 0; j < bq_n + 2; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        model(bq_code[j-2], bq_prot[j-2], d, det, fix, unc, req);
        check("R2", "out_valid", out_valid, 1);
        check(req, "out_data", out_data, d);
        check(req, "det", out_err_det, det);
        check(req, "fix", out_err_fix, fix);
        check(req, "unc", out_err_unc, unc);
        last_d = d; l_det = det; l_fix = fix; l_unc = unc;
      end else begin
        check("R2", "out_valid idle", out_valid, 0);
      end
      if (j < bq_n) begin
        in_valid   = 1'b1;
        in_code    = CW_W'(bq_code[j]);
        in_protect = bq_prot[j];
      end else begin
        in_valid   = 1'b0;
        in_code    = '0;
      end
    end
    for (int j = 0; j < 3; j++) begin
      @(negedge clk);
      check("R7", "out_valid idle", out_valid, 0);
      check("R7", "held data", out_data, last_d);
      check("R7", "held det", out_err_det, l_det);
      check("R7", "held fix", out_err_fix, l_fix);
      check("R7", "held unc", out_err_unc, l_unc);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R8", "out_valid", out_valid, 0);
    check("R8", "out_data", out_data, 0);
    check("R8", "flags", {out_err_det, out_err_fix, out_err_unc}, 0);
  endtask

  task automatic t_encoder();
    longint unsigned v;
    for (int k = 0; k < 8; k++) begin
      v = (k == 0) ? 0 : (k == 1) ? (1 << DATA_W) - 1 : $urandom_range(0, (1 << DATA_W) - 1);
      enc_data = DATA_W'(v);
      @(negedge clk);
      check("R1", "enc_code", enc_code, (v * A) & CMASK);
    end
  endtask

  task automatic t_clean();
    bq_n = 12;
    for (int k = 0; k < bq_n; k++) begin
      bq_code[k] = (k == 0) ? 0 : clean_sum(1 + (k % 8));
      bq_prot[k] = 1;
    end
    run_beats();
  endtask

  task automatic t_single();
    longint unsigned base;
    bq_n = CW_W;
    for (int k = 0; k < bq_n; k++) begin
      base = clean_sum(8);
      // R4: one disturbed position, alternating direction
      if (k % 2 == 0) bq_code[k] = (base - (64'd1 << k)) & CMASK;
      else            bq_code[k] = (base + (64'd1 << k)) & CMASK;
      bq_prot[k] = 1;
    end
    run_beats();
  endtask

  task automatic t_double();
    longint unsigned base;
    int i, j;
    bq_n = 20;
    for (int k = 0; k < bq_n; k++) begin
      base = clean_sum(8);
      i = k % int'(CW_W);
      j = (k * 7 + 3) % int'(CW_W);
      if (j == i) j = (i + 1) % int'(CW_W);
      // R5: two disturbed positions, usually beyond repair
      bq_code[k] = (base - (64'd1 << i) - (64'd1 << j)) & CMASK;
      bq_prot[k] = 1;
    end
    run_beats();
  endtask

  task automatic t_bypass();
    bq_n = 10;
    for (int k = 0; k < bq_n; k++) begin
      bq_code[k] = longint'($urandom()) & CMASK;
      bq_prot[k] = 0;
    end
    run_beats();
  endtask

  task automatic t_mixed();
    bq_n = 32;
    for (int k = 0; k < bq_n; k++) begin
      case (k % 4)
        0: bq_code[k] = clean_sum(4);
        1: bq_code[k] = (clean_sum(4) + (64'd1 << (k % CW_W))) & CMASK;
        2: bq_code[k] = longint'($urandom()) & CMASK;
        default: bq_code[k] = (clean_sum(4) - 64'd3) & CMASK;
      endcase
      bq_prot[k] = (k % 5) != 4;
    end
    run_beats();
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_protect = 1'b0; in_code = '0; enc_data = '0;
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_encoder();
    t_clean();
    t_single();
    t_double();
    t_bypass();
    t_mixed();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule